// File: doc/BRIEF.md
# Descriptor Ring Queue Controller

This block is the register and queue-control front end of a descriptor-driven SMBus host. Software places transaction descriptors in a small ring in memory, tells the block where that ring lives and how many entries it has, then posts work by moving a software head index inside the control register and setting a start bit in a second write. The block keeps its own hardware head index. It offers ring entries one at a time, each with its memory address, to a downstream transaction engine. It keeps going until its head catches up with the software head.

Each finished descriptor advances the hardware head, wrapping at the ring size. A finished descriptor may also set a completion flag or an error flag in the status register. These flags are cleared by writing one to them, and while either is set a level interrupt line stays high. The block also holds a retry-policy word and a two-bit bus-rate selection for the bus engine. Fetching descriptors and driving the bus are done elsewhere; the engine sees only a request/response port.

Top module: `smb_ring_ctrl`

## Requirements
- R1: After reset every register reads zero, no request is offered, irqLine is low and busRate is 0.
- R2: The base address (low word at 0x100, high word at 0x104), the retry word (0x114) and the ring-size field (bits 7:0 of 0x110) read back as written. Bits 31:30 of 0x300 read back and drive busRate (0 = 80 kHz, 1 = 100 kHz, 2 = 400 kHz, 3 = 1 MHz). All other bits of 0x300 read zero.
- R3: Control register 0x108 holds the start bit at bit 0, the error-interrupt enable at bit 4 and the software head at bits 23:16. While start is set and the hardware head differs from the software head, engReqValid is raised with engReqIndex equal to the hardware head and engReqAddr equal to base + 16 × index. The request holds steady until engRspValid.
- R4: Each response advances the hardware head (status 0x10C bits 23:16) by one. After the value held in the size field it wraps to 0.
- R5: When the hardware head equals the software head, start clears by itself and status bit 0 (in progress) reads 0. No further request is offered. Setting start when the heads already match issues nothing.
- R6: A response with engRspIntReq high sets the completion flag, status bit 5.
- R7: A response whose engRspStatus bit 0 (success) is 0 sets the error flag, status bit 4, but only when the error-interrupt enable is set.
- R8: Writing 1 to status bit 5 or bit 4 clears that flag. Writing 0 leaves it. irqLine is high exactly while either flag is set.
- R9: A write to the software head while a request is outstanding is accepted, and the run continues up to the new head.
- R10: The hardware head cannot be written through the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| engReqValid | output | 1 | A descriptor is offered to the engine |
| engReqIndex | output | 8 | Ring index of the offered descriptor |
| engReqAddr | output | 64 | Memory address of the offered descriptor |
| engRspValid | input | 1 | Engine finished the offered descriptor |
| engRspStatus | input | 8 | Returned status byte, bit 0 = success |
| engRspIntReq | input | 1 | Descriptor asked for a completion interrupt |
| irqLine | output | 1 | Level interrupt |
| busRate | output | 2 | Selected bus rate code |

## Verification
The queue is exercised with runs of one, two, three and five descriptors. Some runs cross the ring wrap point and one posts a head equal to the current one. Together these separate correct wrap arithmetic and correct stopping from off-by-one errors and runaway issue. The responses mix success and failure, interrupt request on and off, and error enable on and off, so each flag is tied to its own cause. Directed cases change the head mid-run, write zeros and single ones to the flags, and try to write the hardware head.

// File: rtl/smb_ring_pkg.sv
package smb_ring_pkg;
  localparam int REG_ADDR_W = 12;
  localparam int REG_DATA_W = 32;
  localparam int BASE_W     = 64;

  localparam logic [REG_ADDR_W-1:0] OFS_BASE_LO = 12'h100;
  localparam logic [REG_ADDR_W-1:0] OFS_BASE_HI = 12'h104;
  localparam logic [REG_ADDR_W-1:0] OFS_CTRL    = 12'h108;
  localparam logic [REG_ADDR_W-1:0] OFS_STAT    = 12'h10C;
  localparam logic [REG_ADDR_W-1:0] OFS_SIZE    = 12'h110;
  localparam logic [REG_ADDR_W-1:0] OFS_RETRY   = 12'h114;
  localparam logic [REG_ADDR_W-1:0] OFS_SPEED   = 12'h300;

  localparam int BIT_START  = 0;
  localparam int BIT_ERREN  = 4;
  localparam int BIT_ERRFLG = 4;
  localparam int BIT_INTFLG = 5;
  localparam int HEAD_LSB   = 16;

  typedef struct packed {
    logic advance;
    logic setInt;
    logic setErr;
    logic clearStart;
  } ring_strobe_t;

  typedef enum logic {ST_IDLE, ST_ISSUE} ring_state_t;
endpackage

// File: rtl/smb_ring_seq.sv
module smb_ring_seq
  import smb_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startBit,
  input  logic         headsMatch,
  input  logic         errIntEn,
  input  logic         rspValid,
  input  logic         rspOk,
  input  logic         rspIntReq,
  output logic         reqValid,
  output ring_strobe_t strobe
);
  ring_state_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (startBit) begin
          if (headsMatch) strobe.clearStart = 1'b1;
          else            stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (rspValid) begin
          strobe.advance = 1'b1;
          strobe.setInt  = rspIntReq;
          strobe.setErr  = !rspOk && errIntEn;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqValid = (state == ST_ISSUE);

  // R3: an offered request stays up until the engine answers
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !rspValid) |=> reqValid);
endmodule

// File: rtl/smb_ring_regs.sv
module smb_ring_regs
  import smb_ring_pkg::*;
#(
  parameter int HEAD_W     = 8,
  parameter int DESC_SHIFT = 4
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [REG_DATA_W-1:0] wrData,
  input  ring_strobe_t          strobe,
  output logic [REG_DATA_W-1:0] rdData,
  output logic                  startBit,
  output logic                  errIntEn,
  output logic                  headsMatch,
  output logic [HEAD_W-1:0]     hwHead,
  output logic [BASE_W-1:0]     reqAddr,
  output logic                  irqLine,
  output logic [1:0]            busRate
);
  localparam int HALF_W = BASE_W / 2;

  logic [BASE_W-1:0]     baseAddr;
  logic [HEAD_W-1:0]     swHead, sizeM1, headNext;
  logic [REG_DATA_W-1:0] retryWord;
  logic                  intFlag, errFlag;
  logic                  ctrlWr, statWr;

  assign ctrlWr = wrEn && (addr == OFS_CTRL);
  assign statWr = wrEn && (addr == OFS_STAT);
  assign headNext = (hwHead == sizeM1) ? '0 : hwHead + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseAddr  <= '0;
      swHead    <= '0;
      sizeM1    <= '0;
      retryWord <= '0;
      busRate   <= '0;
      startBit  <= 1'b0;
      errIntEn  <= 1'b0;
    end else begin
      if (wrEn && addr == OFS_BASE_LO) baseAddr[HALF_W-1:0]      <= wrData;
      if (wrEn && addr == OFS_BASE_HI) baseAddr[BASE_W-1:HALF_W] <= wrData;
      if (wrEn && addr == OFS_SIZE)    sizeM1    <= wrData[HEAD_W-1:0];
      if (wrEn && addr == OFS_RETRY)   retryWord <= wrData;
      if (wrEn && addr == OFS_SPEED)   busRate   <= wrData[31:30];
      if (ctrlWr) begin
        startBit <= wrData[BIT_START];
        errIntEn <= wrData[BIT_ERREN];
        swHead   <= wrData[HEAD_LSB +: HEAD_W];
      end else if (strobe.clearStart) begin
        startBit <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hwHead  <= '0;
      intFlag <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.advance) hwHead <= headNext;
      intFlag <= strobe.setInt || (intFlag && !(statWr && wrData[BIT_INTFLG]));
      errFlag <= strobe.setErr || (errFlag && !(statWr && wrData[BIT_ERRFLG]));
    end
  end

  assign headsMatch = (hwHead == swHead);
  assign reqAddr    = baseAddr + (BASE_W'(hwHead) << DESC_SHIFT);
  assign irqLine    = intFlag || errFlag;

  always_comb begin
    rdData = '0;
    case (addr)
      OFS_BASE_LO: rdData = baseAddr[HALF_W-1:0];
      OFS_BASE_HI: rdData = baseAddr[BASE_W-1:HALF_W];
      OFS_CTRL: begin
        rdData[BIT_START]            = startBit;
        rdData[BIT_ERREN]            = errIntEn;
        rdData[HEAD_LSB +: HEAD_W]   = swHead;
      end
      OFS_STAT: begin
        rdData[BIT_START]            = startBit;
        rdData[BIT_ERRFLG]           = errFlag;
        rdData[BIT_INTFLG]           = intFlag;
        rdData[HEAD_LSB +: HEAD_W]   = hwHead;
      end
      OFS_SIZE:  rdData[HEAD_W-1:0] = sizeM1;
      OFS_RETRY: rdData = retryWord;
      OFS_SPEED: rdData[31:30] = busRate;
      default:   rdData = '0;
    endcase
  end

  // R7: the error flag only rises while error interrupts are enabled
  p_err_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errFlag) |-> $past(errIntEn));
  // R8: a raised flag survives any cycle without a clearing write
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (intFlag && !(statWr && wrData[BIT_INTFLG])) |=> intFlag);
  // R10: the hardware head moves only on a completion
  p_head_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance |=> $stable(hwHead));
  // R5: start drops by itself only once the heads meet
  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(startBit) && !$past(ctrlWr)) |-> $past(headsMatch));
endmodule

// File: rtl/smb_ring_ctrl.sv
module smb_ring_ctrl
  import smb_ring_pkg::*;
#(
  parameter int HEAD_W     = 8,
  parameter int DESC_SHIFT = 4
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [REG_DATA_W-1:0] regWrData,
  output logic [REG_DATA_W-1:0] regRdData,
  output logic                  engReqValid,
  output logic [HEAD_W-1:0]     engReqIndex,
  output logic [BASE_W-1:0]     engReqAddr,
  input  logic                  engRspValid,
  input  logic [7:0]            engRspStatus,
  input  logic                  engRspIntReq,
  output logic                  irqLine,
  output logic [1:0]            busRate
);
  ring_strobe_t strobe;
  logic startBit, errIntEn, headsMatch;

  smb_ring_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .startBit(startBit), .headsMatch(headsMatch), .errIntEn(errIntEn),
    .rspValid(engRspValid), .rspOk(engRspStatus[0]), .rspIntReq(engRspIntReq),
    .reqValid(engReqValid), .strobe(strobe)
  );

  smb_ring_regs #(.HEAD_W(HEAD_W), .DESC_SHIFT(DESC_SHIFT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData), .strobe(strobe),
    .rdData(regRdData), .startBit(startBit), .errIntEn(errIntEn),
    .headsMatch(headsMatch), .hwHead(engReqIndex), .reqAddr(engReqAddr),
    .irqLine(irqLine), .busRate(busRate)
  );

  // R4: a response retires the offered request on the next cycle
  p_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (engReqValid && engRspValid) |=> !engReqValid);
endmodule

// File: tb/tb_smb_ring_ctrl.sv
module tb_smb_ring_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        engReqValid;
  logic [7:0]  engReqIndex;
  logic [63:0] engReqAddr;
  logic        engRspValid = 1'b0;
  logic [7:0]  engRspStatus = '0;
  logic        engRspIntReq = 1'b0;
  logic        irqLine;
  logic [1:0]  busRate;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0]  expHead = '0;
  logic [63:0] baseVal = 64'h0000_00AB_1000_0000;

  always #10 clk = ~clk;

  smb_ring_ctrl dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .engReqValid(engReqValid),
    .engReqIndex(engReqIndex), .engReqAddr(engReqAddr), .engRspValid(engRspValid),
    .engRspStatus(engRspStatus), .engRspIntReq(engRspIntReq),
    .irqLine(irqLine), .busRate(busRate)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog act %0d exp below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [7:0] wrapNext(input logic [7:0] h, input logic [7:0] s);
    return (h == s) ? 8'd0 : h + 8'd1;
  endfunction

  // serve requests until start clears; returns number served
  task automatic serve(input logic [7:0] st, input logic ir, input logic [7:0] sz,
                       output int served);
    served = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (engReqValid) begin
        chk("R3 index", engReqIndex, expHead);
        chk("R3 addr", engReqAddr, baseVal + 64'(expHead) * 64'd16);
        engRspValid = 1'b1; engRspStatus = st; engRspIntReq = ir;
        @(negedge clk);
        engRspValid = 1'b0;
        expHead = wrapNext(expHead, sz);
        served++;
      end else begin
        regAddr = 12'h10C;
        #1;
        if (!regRdData[0]) break;
      end
    end
  endtask

  // {target, sizeM1, status, intReq, errEn}
  localparam logic [25:0] VEC [7] = '{
    {8'd2, 8'd3, 8'h01, 1'b1, 1'b1},
    {8'd1, 8'd3, 8'h01, 1'b0, 1'b1},
    {8'd2, 8'd3, 8'h08, 1'b0, 1'b1},
    {8'd3, 8'd3, 8'h08, 1'b1, 1'b0},
    {8'd3, 8'd3, 8'h01, 1'b1, 1'b1},
    {8'd0, 8'd7, 8'h01, 1'b0, 1'b0},
    {8'd1, 8'd1, 8'h00, 1'b1, 1'b1}
  };

  logic [31:0] rd;
  int n;

  initial begin
    #35 rst_n = 1'b1;
    // R1 reset state
    regRead(12'h100, rd); chk("R1 base", rd, 0);
    regRead(12'h108, rd); chk("R1 ctrl", rd, 0);
    regRead(12'h10C, rd); chk("R1 stat", rd, 0);
    regRead(12'h110, rd); chk("R1 size", rd, 0);
    chk("R1 req", engReqValid, 0);
    chk("R1 irq", irqLine, 0);
    chk("R1 rate", busRate, 0);

    // R2 register storage
    regWrite(12'h100, baseVal[31:0]);
    regWrite(12'h104, baseVal[63:32]);
    regWrite(12'h114, 32'hCAFE_0123);
    regWrite(12'h300, 32'hBFFF_FFFF);
    regRead(12'h100, rd); chk("R2 base lo", rd, baseVal[31:0]);
    regRead(12'h104, rd); chk("R2 base hi", rd, baseVal[63:32]);
    regRead(12'h114, rd); chk("R2 retry", rd, 32'hCAFE_0123);
    regRead(12'h300, rd); chk("R2 speed", rd, 32'h8000_0000);
    chk("R2 rate", busRate, 2'd2);

    // table of posted runs
    foreach (VEC[k]) begin
      logic [7:0] tgt, sz, st;
      logic ir, ee;
      int expN;
      logic [7:0] h;
      {tgt, sz, st, ir, ee} = VEC[k];
      expN = 0; h = expHead;
      while (h != tgt && expN < 256) begin h = wrapNext(h, sz); expN++; end
      regWrite(12'h10C, 32'h30);
      regWrite(12'h110, {24'd0, sz});
      regWrite(12'h108, {8'd0, tgt, 11'd0, ee, 4'd0});
      regWrite(12'h108, {8'd0, tgt, 11'd0, ee, 3'd0, 1'b1});
      serve(st, ir, sz, n);
      chk("R4 R5 count", n, expN);
      regRead(12'h10C, rd);
      chk("R4 hw head", rd[23:16], tgt);
      chk("R5 busy clear", rd[0], 0);
      chk("R6 int flag", rd[5], ir && expN > 0);
      chk("R7 err flag", rd[4], ee && !st[0] && expN > 0);
      chk("R8 irq level", irqLine, (ir || (ee && !st[0])) && expN > 0);
      regRead(12'h108, rd);
      chk("R5 start clear", rd[0], 0);
    end

    // R8: zero write keeps flags, single one clears only its flag
    regWrite(12'h10C, 32'h30);
    regWrite(12'h110, 32'd7);
    regWrite(12'h108, {8'd0, expHead + 8'd1, 11'd0, 1'b1, 3'd0, 1'b1});
    serve(8'h00, 1'b1, 8'd7, n);
    regWrite(12'h10C, 32'h0);
    regRead(12'h10C, rd); chk("R8 zero write keeps", rd[5:4], 2'b11);
    regWrite(12'h10C, 32'h20);
    regRead(12'h10C, rd); chk("R8 int cleared only", rd[5:4], 2'b01);
    chk("R8 irq still high", irqLine, 1);
    regWrite(12'h10C, 32'h10);
    chk("R8 irq low", irqLine, 0);

    // R10: status write cannot move hw head
    regWrite(12'h10C, 32'h00FF_0000);
    regRead(12'h10C, rd); chk("R10 hw head kept", rd[23:16], expHead);

    // R9: head moved while a request is outstanding
    begin
      logic [7:0] tgt2;
      tgt2 = wrapNext(wrapNext(wrapNext(expHead, 8'd7), 8'd7), 8'd7);
      regWrite(12'h108, {8'd0, wrapNext(expHead, 8'd7), 16'h0001});
      for (int i = 0; i < 10 && !engReqValid; i++) @(negedge clk);
      chk("R9 request up", engReqValid, 1);
      regWrite(12'h108, {8'd0, tgt2, 16'h0001});
      serve(8'h01, 1'b0, 8'd7, n);
      chk("R9 extended count", n, 3);
      regRead(12'h10C, rd); chk("R9 hw head", rd[23:16], tgt2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule